// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight edge-type interrupt inputs into a pending set, drives a single interrupt line toward an upstream interrupt router, and answers that router's acknowledge with an 8-bit vector. A rising edge on an unmasked input marks that input as pending. The interrupt line is raised when some pending input is not shadowed by an in-service input at its own or a higher position. Higher input numbers have higher priority.

On an acknowledge, the controller promotes the highest-numbered pending input to in-service. It returns that input's number in the low three bits of the vector, below a programmable base. An input can be marked as a cascade input. When such an input wins and a downstream controller is attached, the acknowledge is forwarded down, and the downstream controller's vector is passed up unchanged. Only one downstream controller is supported.

Software programs the controller through a small write port. That port sets the mask, the vector base and the cascade map. It also accepts an end-of-interrupt command, which retires the highest in-service input.

Both acknowledge ports use a four-phase request/acknowledge handshake, which is the back-pressure rule at the block's edge:
- The requester raises its request and holds it until it sees the acknowledge.
- The responder holds the acknowledge, with a stable vector, until the request falls.
- The requester must not raise a new request until the acknowledge has fallen.

Top module: `cpic_top`

## Requirements
- R1: Reset empties the pending and in-service sets, sets all eight mask bits, clears the cascade map and vector base, and holds `int_o`, `up_ack_o` and `sl_req_o` low. Because every input is masked after reset, edges seen before software clears the mask are lost.
- R2: A rising edge on an input whose mask bit is 1 is discarded. Clearing that mask bit later does not bring it back, so `int_o` stays low and an acknowledge returns the spurious vector.
- R3: A rising edge (a 0-to-1 change sampled on `clk`) on an input whose mask bit is 0 makes that input pending. `int_o` reflects it after that clock edge. An input held high yields exactly one pending request.
- R4: `int_o` is 1 exactly when there is a pending input L such that no in-service bit is set at position L or above.
- R5: On an acknowledge with pending inputs, the highest-numbered pending input L leaves the pending set and enters the in-service set. The vector is `{base[4:0], L[2:0]}`, with the base taken from write-data bits 7:3 of a base write.
- R6: If the winning input's cascade-map bit is 1 and `slave_present_i` is 1, the block runs a four-phase handshake on `sl_req_o`/`sl_ack_i`. It then returns the `sl_vector_i` value captured while `sl_ack_i` was high.
- R7: If the winning input's cascade-map bit is 1 and `slave_present_i` is 0, no downstream handshake occurs, and the vector is formed as in R5.
- R8: An acknowledge with nothing pending returns the spurious vector `{base, 3'b111}` and changes neither the pending nor the in-service set.
- R9: An end-of-interrupt write clears only the highest set in-service bit. `int_o` is then re-evaluated against the remaining pending inputs. With nothing in service, the write has no effect.
- R10: Once `up_ack_o` rises, it stays high and `up_vector_o` stays unchanged until `up_req_i` falls. `up_ack_o` falls on the clock edge after the request falls. `sl_req_o` stays high until `sl_ack_i` is seen.
- R11: Write port encoding when `cfg_we_i` is 1:
  - `cfg_sel_i` = 0 loads the mask from `cfg_wdata_i[7:0]`, where bit i masks input i.
  - 1 loads the base from `cfg_wdata_i[7:3]`.
  - 2 loads the cascade map from `cfg_wdata_i[7:0]`, where bit i marks input i.
  - 3 issues end-of-interrupt, and the data is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Edge-type interrupt inputs, bit i is input i |
| cfg_we_i | input | 1 | Write strobe for the configuration port |
| cfg_sel_i | input | 2 | Write target: 0 mask, 1 base, 2 cascade map, 3 end-of-interrupt |
| cfg_wdata_i | input | 8 | Write data |
| int_o | output | 1 | Interrupt line toward the upstream router |
| up_req_i | input | 1 | Upstream acknowledge request |
| up_ack_o | output | 1 | Upstream acknowledge, vector valid while high |
| up_vector_o | output | 8 | Vector returned upstream |
| slave_present_i | input | 1 | High when a downstream controller is attached |
| sl_req_o | output | 1 | Acknowledge request to the downstream controller |
| sl_ack_i | input | 1 | Downstream acknowledge |
| sl_vector_i | input | 8 | Vector from the downstream controller, valid while `sl_ack_i` is high |

## Verification
The bench targets in-service shadowing. When a low input is raised while a higher input is in service, `int_o` must stay low, and must rise again only after end-of-interrupt retires the blocker; a design that compares against only the equal position, or ignores the in-service set, raises the line too early. It checks that end-of-interrupt clears only the top in-service bit, since clearing all bits or the lowest bit releases the wrong inputs. It checks that a masked edge stays lost after unmasking, and that a held input counts once; a level-sensitive capture would produce repeated acknowledges. For cascade inputs, it checks that the downstream vector is used only when a controller is attached, and that the spurious vector carries the programmed base.

// File: rtl/cpic_pkg.sv
package cpic_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE    = 2'd0,
    ACK_SLV_REQ = 2'd1,
    ACK_SLV_REL = 2'd2,
    ACK_UP_HOLD = 2'd3
  } ack_state_e;

  localparam logic [1:0] CFG_MASK    = 2'd0;
  localparam logic [1:0] CFG_BASE    = 2'd1;
  localparam logic [1:0] CFG_CASCADE = 2'd2;
  localparam logic [1:0] CFG_EOI     = 2'd3;

endpackage

// File: rtl/cpic_hi_pick.sv
module cpic_hi_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec_i,
  output logic [N-1:0] onehot_o,
  output logic         any_o
);

  logic found;

  always_comb begin
    onehot_o = '0;
    found    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i] && !found) begin
        onehot_o[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign any_o = |vec_i;

endmodule

// File: rtl/cpic_req_capture.sv
module cpic_req_capture #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] irq_q;
  logic [N-1:0] rise;
  logic [N-1:0] pend_q;

  assign rise = irq_i & ~irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= '0;
      pend_q <= '0;
    end else begin
      irq_q  <= irq_i;
      pend_q <= (pend_q | (rise & ~mask_i)) & ~clr_i;
    end
  end

  assign pend_o = pend_q;

  // A pending bit only appears where an unmasked edge was seen
  assert_masked_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~$past(pend_q)) & ~$past(rise & ~mask_i)) == '0);

endmodule

// File: rtl/cpic_ack_fsm.sv
module cpic_ack_fsm
  import cpic_pkg::*;
#(
  parameter int N     = 8,
  parameter int VEC_W = 8,
  parameter int LW    = $clog2(N),
  parameter int OFF_W = VEC_W - LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req_i,
  input  logic [N-1:0]     pend_onehot_i,
  input  logic             pend_any_i,
  input  logic [N-1:0]     cascade_i,
  input  logic [OFF_W-1:0] base_i,
  input  logic             slave_present_i,
  input  logic             sl_ack_i,
  input  logic [VEC_W-1:0] sl_vector_i,
  output logic [N-1:0]     grant_o,
  output logic             up_ack_o,
  output logic [VEC_W-1:0] up_vector_o,
  output logic             sl_req_o
);

  ack_state_e       state_q;
  logic [VEC_W-1:0] vec_q;
  logic [LW-1:0]    win_idx;
  logic             win_cascade;
  logic             accept;

  always_comb begin
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_onehot_i[i]) win_idx = LW'(i);
    end
  end

  assign win_cascade = |(pend_onehot_i & cascade_i);
  assign accept      = (state_q == ACK_IDLE) && up_req_i;
  assign grant_o     = accept ? pend_onehot_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACK_IDLE;
      vec_q   <= '0;
    end else begin
      unique case (state_q)
        ACK_IDLE: begin
          if (up_req_i) begin
            if (pend_any_i && win_cascade && slave_present_i) begin
              state_q <= ACK_SLV_REQ;
            end else begin
              state_q <= ACK_UP_HOLD;
              vec_q   <= pend_any_i ? {base_i, win_idx} : {base_i, {LW{1'b1}}};
            end
          end
        end
        ACK_SLV_REQ: begin
          if (sl_ack_i) begin
            vec_q   <= sl_vector_i;
            state_q <= ACK_SLV_REL;
          end
        end
        ACK_SLV_REL: begin
          if (!sl_ack_i) state_q <= ACK_UP_HOLD;
        end
        ACK_UP_HOLD: begin
          if (!up_req_i) state_q <= ACK_IDLE;
        end
        default: state_q <= ACK_IDLE;
      endcase
    end
  end

  assign up_ack_o    = (state_q == ACK_UP_HOLD);
  assign sl_req_o    = (state_q == ACK_SLV_REQ);
  assign up_vector_o = vec_q;

  assert_ack_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack_o && up_req_i) |=> up_ack_o);

  assert_vec_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_ack_o && up_req_i) |=> $stable(up_vector_o));

  assert_slave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sl_req_o && !sl_ack_i) |=> sl_req_o);

  assert_grant_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

endmodule

// File: rtl/cpic_top.sv
module cpic_top
  import cpic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  localparam int LINE_W   = $clog2(NUM_LINES),
  localparam int OFF_W    = VEC_W - LINE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_sel_i,
  input  logic [VEC_W-1:0]     cfg_wdata_i,
  output logic                 int_o,
  input  logic                 up_req_i,
  output logic                 up_ack_o,
  output logic [VEC_W-1:0]     up_vector_o,
  input  logic                 slave_present_i,
  output logic                 sl_req_o,
  input  logic                 sl_ack_i,
  input  logic [VEC_W-1:0]     sl_vector_i
);

  logic [NUM_LINES-1:0] mask_q;
  logic [NUM_LINES-1:0] cascade_q;
  logic [OFF_W-1:0]     base_q;
  logic [NUM_LINES-1:0] isr_q;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] pend_onehot;
  logic                 pend_any;
  logic [NUM_LINES-1:0] isr_onehot;
  logic                 isr_any;
  logic [NUM_LINES-1:0] grant;
  logic [NUM_LINES-1:0] blocked;
  logic                 eoi;

  assign eoi = cfg_we_i && (cfg_sel_i == CFG_EOI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      cascade_q <= '0;
      base_q    <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i == CFG_MASK)    mask_q    <= cfg_wdata_i[NUM_LINES-1:0];
      if (cfg_sel_i == CFG_BASE)    base_q    <= cfg_wdata_i[VEC_W-1:LINE_W];
      if (cfg_sel_i == CFG_CASCADE) cascade_q <= cfg_wdata_i[NUM_LINES-1:0];
    end
  end

  cpic_req_capture #(.N(NUM_LINES)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_i  (irq_i),
    .mask_i (mask_q),
    .clr_i  (grant),
    .pend_o (pend)
  );

  cpic_hi_pick #(.N(NUM_LINES)) u_pend_pick (
    .vec_i    (pend),
    .onehot_o (pend_onehot),
    .any_o    (pend_any)
  );

  cpic_hi_pick #(.N(NUM_LINES)) u_isr_pick (
    .vec_i    (isr_q),
    .onehot_o (isr_onehot),
    .any_o    (isr_any)
  );

  cpic_ack_fsm #(.N(NUM_LINES), .VEC_W(VEC_W)) u_ack (
    .clk             (clk),
    .rst_n           (rst_n),
    .up_req_i        (up_req_i),
    .pend_onehot_i   (pend_onehot),
    .pend_any_i      (pend_any),
    .cascade_i       (cascade_q),
    .base_i          (base_q),
    .slave_present_i (slave_present_i),
    .sl_ack_i        (sl_ack_i),
    .sl_vector_i     (sl_vector_i),
    .grant_o         (grant),
    .up_ack_o        (up_ack_o),
    .up_vector_o     (up_vector_o),
    .sl_req_o        (sl_req_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else begin
      isr_q <= (isr_q & ~(eoi ? isr_onehot : '0)) | grant;
    end
  end

  // Input L is shadowed when any in-service bit sits at L or above
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_block
    assign blocked[l] = |isr_q[NUM_LINES-1:l];
  end

  assign int_o = |(pend & ~blocked);

  assert_int_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> pend_any);

  assert_eoi_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && isr_any && (grant == '0)) |=>
      ($countones(isr_q) == $countones($past(isr_q)) - 1));

  assert_grant_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> ((grant & pend) == grant));

endmodule

// File: tb/tb_cpic_top.sv
module tb_cpic_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic       int_o;
  logic       up_req = 1'b0;
  logic       up_ack;
  logic [7:0] up_vector;
  logic       slave_present = 1'b0;
  logic       sl_req;
  logic       sl_ack = 1'b0;
  logic [7:0] sl_vector = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int slave_hs = 0;
  bit done = 0;

  logic [7:0] m_pend = '0, m_isr = '0, m_mask = 8'hFF, m_casc = '0;
  logic [4:0] m_base = '0;
  logic [7:0] slave_vec = 8'h9A;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpic_top dut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .int_o(int_o), .up_req_i(up_req), .up_ack_o(up_ack),
    .up_vector_o(up_vector), .slave_present_i(slave_present), .sl_req_o(sl_req),
    .sl_ack_i(sl_ack), .sl_vector_i(sl_vector)
  );

  // Downstream controller model
  initial begin
    int wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (sl_req && !sl_ack) begin
        wait_cnt++;
        if (wait_cnt >= 2) begin
          sl_vector = slave_vec;
          sl_ack    = 1'b1;
          wait_cnt  = 0;
          slave_hs++;
        end
      end else if (!sl_req && sl_ack) begin
        sl_ack = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] top_bit(input logic [7:0] v);
    logic [7:0] r = '0;
    for (int i = 7; i >= 0; i--) if (v[i] && r == '0) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_int(input logic [7:0] p, input logic [7:0] s);
    logic r = 1'b0;
    for (int l = 0; l < 8; l++) if (p[l] && ((s >> l) == 0)) r = 1'b1;
    return r;
  endfunction

  function automatic int bit_idx(input logic [7:0] oh);
    int r = 0;
    for (int i = 0; i < 8; i++) if (oh[i]) r = i;
    return r;
  endfunction

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag);
    check_eq(tag, int'(int_o), int'(exp_int(m_pend, m_isr)));
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk);
    irq = lines;
    m_pend = m_pend | (lines & ~m_mask);
    @(negedge clk);
    irq = '0;
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    case (sel)
      2'd0: m_mask = d;
      2'd1: m_base = d[7:3];
      2'd2: m_casc = d;
      default: m_isr = m_isr & ~top_bit(m_isr);
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_ack(input string tag);
    logic [7:0] exp_v;
    logic [7:0] win;
    logic [7:0] v0;
    int hs0 = slave_hs;
    bit use_slave = 0;
    int n = 0;
    win = top_bit(m_pend);
    if (win == '0) exp_v = {m_base, 3'b111};
    else if ((win & m_casc) != 0 && slave_present) begin
      exp_v = slave_vec; use_slave = 1;
    end else exp_v = {m_base, 3'(bit_idx(win))};
    m_pend = m_pend & ~win;
    m_isr  = m_isr | win;
    @(negedge clk);
    up_req = 1'b1;
    while (!up_ack && n < 50) begin
      @(negedge clk);
      n++;
    end
    check_eq({tag, " vector"}, int'(up_vector), int'(exp_v));
    check_eq({tag, " slave handshakes"}, slave_hs - hs0, use_slave ? 1 : 0);
    v0 = up_vector;
    @(negedge clk);
    check_eq("R10 ack held", int'(up_ack), 1);
    check_eq("R10 vector stable", int'(up_vector), int'(v0));
    up_req = 1'b0;
    @(negedge clk);
    check_eq("R10 ack released", int'(up_ack), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_eq("R1 int after reset", int'(int_o), 0);
    check_eq("R1 up_ack after reset", int'(up_ack), 0);
    check_eq("R1 sl_req after reset", int'(sl_req), 0);
    rst_n = 1'b1;
    pulse(8'hFF);
    check_eq("R1 masked at reset int", int'(int_o), 0);
    do_ack("R1 R8 spurious after reset");

    cfg_write(2'd1, 8'h20);
    cfg_write(2'd0, 8'h00);
    pulse(8'h08);
    check_eq("R3 edge sets int", int'(int_o), 1);
    do_ack("R5 line3");
    check_int("R5 int cleared");
    pulse(8'h02);
    check_eq("R4 shadowed low line", int'(int_o), 0);
    pulse(8'h20);
    check_eq("R4 higher line passes", int'(int_o), 1);
    do_ack("R5 line5");
    cfg_write(2'd3, 8'hA5);
    check_eq("R9 eoi clears only top", int'(int_o), 0);
    cfg_write(2'd3, 8'h00);
    check_eq("R9 eoi releases line1", int'(int_o), 1);
    do_ack("R5 line1");
    cfg_write(2'd3, 8'h00);
    cfg_write(2'd3, 8'h00);
    check_int("R9 eoi empty no effect");

    @(negedge clk); irq = 8'h04; m_pend = m_pend | 8'h04;
    repeat (5) @(negedge clk);
    do_ack("R3 held line once");
    do_ack("R3 R8 no second request");
    irq = '0;
    cfg_write(2'd3, 8'h00);

    cfg_write(2'd2, 8'h04);
    slave_present = 1'b1;
    pulse(8'h04);
    do_ack("R6 cascade to slave");
    cfg_write(2'd3, 8'h00);
    slave_present = 1'b0;
    pulse(8'h04);
    do_ack("R7 cascade without slave");
    cfg_write(2'd3, 8'h00);

    cfg_write(2'd0, 8'h10);
    pulse(8'h10);
    cfg_write(2'd0, 8'h00);
    check_eq("R2 masked edge lost", int'(int_o), 0);
    do_ack("R2 R8 spurious after masked edge");
    cfg_write(2'd3, 8'h00);

    for (int it = 0; it < 400; it++) begin
      int op = int'($urandom_range(0, 9));
      if (op <= 2) pulse(8'($urandom));
      else if (op <= 4) do_ack("R5 R6 R7 R8 random ack");
      else if (op <= 6) cfg_write(2'd3, 8'($urandom));
      else if (op == 7) cfg_write(2'd0, 8'($urandom & $urandom));
      else if (op == 8) cfg_write(2'd1, 8'($urandom));
      else begin
        slave_vec = 8'($urandom);
        slave_present = 1'($urandom);
        cfg_write(2'd2, 8'($urandom));
      end
      check_int("R4 R9 R11 random int");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule